// File: doc/BRIEF.md
# Scanline Counter with Horizontal Sync Wait

This block keeps the raster position for a video generator. A horizontal counter steps once per pixel clock and wraps at the end of each line. A line counter advances each time a new line starts and wraps at the end of the frame. Horizontal blanking is the first part of every line. It begins at horizontal position 0, on the same edge where the line counter steps.

The processor reaches the block through a small register bus. Reading the line-position address gives the line counter at half resolution. Writing any value to the sync-wait address arms a latch. While the latch is armed, the processor ready line is held low, which stalls the processor. The latch disarms itself when the next horizontal blank begins. Software uses this to hold itself to the start of a line.

Top module: `scanline_sync_top`

## Requirements
- R1: While reset is asserted, the line-position read returns 0, `cpu_rdy` is 1 and `hblank` is 1 (horizontal position 0).
- R2: The horizontal position runs 0 to LINE_CLKS-1 and advances once per clock after reset. `hblank` is 1 exactly when the position is below HBLANK_CLKS.
- R3: The line counter goes up by one on the edge where the horizontal position wraps to 0, which is the edge where `hblank` rises. At all other times it holds.
- R4: After line LINES-1, the line counter returns to 0.
- R5: A read is `bus_sel`=1, `bus_we`=0 with `bus_addr`=LINE_ADDR. In that same cycle, `bus_rdata` carries line-counter bits 8 down to 1 on data bits 7 down to 0. Bit 0 is never visible, so lines 2k and 2k+1 read the same value.
- R6: `bus_rdata` is 0 whenever the bus is not performing that read. This covers idle cycles, writes and other addresses.
- R7: A write is `bus_sel`=1, `bus_we`=1 with `bus_addr`=WAIT_ADDR. The data value does not matter. The write drives `cpu_rdy` to 0 from the next cycle.
- R8: The latch releases on the edge where the horizontal position next wraps to 0. `cpu_rdy` returns to 1 in the same cycle that `hblank` rises.
- R9: A wait write sampled on the final clock of a line, where that edge itself wraps the position, keeps `cpu_rdy` at 0 until the wrap one full line later.
- R10: Writes to any other address, and reads of WAIT_ADDR, leave `cpu_rdy` and the line counter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register offset |
| bus_wdata | input | DATA_W | Write data (value ignored) |
| bus_rdata | output | DATA_W | Line position read data, 0 when not read |
| cpu_rdy | output | 1 | Processor ready, low while a sync wait is pending |
| hblank | output | 1 | High during horizontal blanking |

## Verification
The bench targets the exact cycle on which the wait latch clears. A design that clears one edge early or late shows a misplaced `cpu_rdy` rise relative to the `hblank` rise. It also writes the wait address on the last clock of a line. A design that lets the wrap beat the write releases the processor at once instead of a line later. Reads are taken at lines on both sides of odd/even pairs and across the frame wrap. These catch a design that exposes bit 0, shifts the field the wrong way or wraps at the wrong line. Writes to the read address and reads of the wait address are used to expose decoding that arms the latch on the wrong access.

// File: rtl/scanline_pkg.sv
package scanline_pkg;

  typedef struct packed {
    logic rd_line;
    logic wr_wait;
  } scan_access_t;

  function automatic scan_access_t scan_decode(
    input logic sel,
    input logic we,
    input logic [7:0] addr,
    input logic [7:0] line_addr,
    input logic [7:0] wait_addr
  );
    scan_access_t acc;
    acc.rd_line = sel & ~we & (addr == line_addr);
    acc.wr_wait = sel & we & (addr == wait_addr);
    return acc;
  endfunction

endpackage

// File: rtl/scan_rst_sync.sv
module scan_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/scan_hcount.sv
module scan_hcount #(
  parameter int LINE_CLKS   = 228,
  parameter int HBLANK_CLKS = 68,
  parameter int HCNT_W      = 8
) (
  input  logic clk,
  input  logic rst_n,
  output logic line_end,
  output logic hblank
);

  logic [HCNT_W-1:0] hpos_q;
  logic [HCNT_W-1:0] hpos_d;

  always_comb begin
    line_end = (hpos_q == HCNT_W'(LINE_CLKS - 1));
    if (line_end) begin
      hpos_d = '0;
    end else begin
      hpos_d = hpos_q + 1'b1;
    end
    hblank = (hpos_q < HCNT_W'(HBLANK_CLKS));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hpos_q <= '0;
    end else begin
      hpos_q <= hpos_d;
    end
  end

  AST_HPOS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    hpos_q < HCNT_W'(LINE_CLKS)); // R2
  AST_HPOS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !line_end |=> hpos_q == $past(hpos_q) + 1'b1); // R2
  AST_HPOS_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    line_end |=> (hpos_q == '0) && hblank); // R3

endmodule

// File: rtl/scan_vcount.sv
module scan_vcount #(
  parameter int LINES  = 262,
  parameter int VCNT_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv_en,
  output logic [VCNT_W-1:0] vline
);

  logic [VCNT_W-1:0] vline_q;
  logic [VCNT_W-1:0] vline_d;
  logic              at_last;

  always_comb begin
    at_last = (vline_q == VCNT_W'(LINES - 1));
    if (at_last) begin
      vline_d = '0;
    end else begin
      vline_d = vline_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vline_q <= '0;
    end else if (adv_en) begin
      vline_q <= vline_d;
    end
  end

  assign vline = vline_q;

  AST_VLINE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_en |=> $stable(vline_q)); // R3
  AST_VLINE_ADV: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_en && !at_last) |=> vline_q == $past(vline_q) + 1'b1); // R3
  AST_VLINE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_en && at_last) |=> vline_q == '0); // R4
  AST_VLINE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    vline_q < VCNT_W'(LINES)); // R4

endmodule

// File: rtl/scan_wait_latch.sv
module scan_wait_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_req,
  input  logic blank_start,
  output logic cpu_rdy
);

  logic armed_q;
  logic armed_d;

  always_comb begin
    armed_d = arm_req | (armed_q & ~blank_start);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
    end else begin
      armed_q <= armed_d;
    end
  end

  assign cpu_rdy = ~armed_q;

  AST_WAIT_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    arm_req |=> !cpu_rdy); // R7
  AST_WAIT_EDGE_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_req && blank_start) |=> !cpu_rdy); // R9
  AST_WAIT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (blank_start && !arm_req) |=> cpu_rdy); // R8
  AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_rdy && !blank_start) |=> !cpu_rdy); // R8

endmodule

// File: rtl/scanline_sync_top.sv
module scanline_sync_top #(
  parameter int          LINE_CLKS   = 228,
  parameter int          HBLANK_CLKS = 68,
  parameter int          LINES       = 262,
  parameter int          DATA_W      = 8,
  parameter int          ADDR_W      = 4,
  parameter int          SYNC_STAGES = 2,
  parameter logic [7:0]  LINE_ADDR   = 8'h3,
  parameter logic [7:0]  WAIT_ADDR   = 8'h2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              cpu_rdy,
  output logic              hblank
);

  import scanline_pkg::*;

  localparam int HCNT_W = $clog2(LINE_CLKS);
  localparam int VCNT_W = DATA_W + 1;

  logic              rst_int_n;
  logic              line_end;
  logic [VCNT_W-1:0] vline;
  scan_access_t      acc;
  logic              unused_wdata;
  logic              unused_vline_lsb;

  assign unused_wdata     = ^bus_wdata;
  assign unused_vline_lsb = vline[0];

  scan_rst_sync #(
    .STAGES (SYNC_STAGES)
  ) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  scan_hcount #(
    .LINE_CLKS   (LINE_CLKS),
    .HBLANK_CLKS (HBLANK_CLKS),
    .HCNT_W      (HCNT_W)
  ) u_hcount (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .line_end (line_end),
    .hblank   (hblank)
  );

  scan_vcount #(
    .LINES  (LINES),
    .VCNT_W (VCNT_W)
  ) u_vcount (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .adv_en (line_end),
    .vline  (vline)
  );

  always_comb begin
    acc = scan_decode(bus_sel, bus_we, 8'(bus_addr), LINE_ADDR, WAIT_ADDR);
  end

  scan_wait_latch u_wait (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .arm_req     (acc.wr_wait),
    .blank_start (line_end),
    .cpu_rdy     (cpu_rdy)
  );

  always_comb begin
    if (acc.rd_line) begin
      bus_rdata = vline[VCNT_W-1:1];
    end else begin
      bus_rdata = '0;
    end
  end

  AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(bus_sel && !bus_we && (8'(bus_addr) == LINE_ADDR)) |-> bus_rdata == '0); // R6
  AST_NO_STRAY_ARM: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cpu_rdy && !(bus_sel && bus_we && (8'(bus_addr) == WAIT_ADDR))) |=> cpu_rdy); // R10

endmodule

// File: tb/scanline_sync_top_tb_top.sv
module scanline_sync_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int L   = 24;
  localparam int HB  = 8;
  localparam int NL  = 262;
  localparam int SYN = 2;
  localparam logic [3:0] A_LINE = 4'h3;
  localparam logic [3:0] A_WAIT = 4'h2;

  localparam int K_RDATA  = 0;
  localparam int K_RDY    = 1;
  localparam int K_HBLANK = 2;

  typedef struct {
    int    due;
    int    kind;
    int    expv;
    string tag;
  } item_t;

  logic       clk;
  logic       rst_n;
  logic       bus_sel;
  logic       bus_we;
  logic [3:0] bus_addr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       cpu_rdy;
  logic       hblank;

  int    cyc;
  int    checks;
  int    errors;
  bit    done;
  int    lat_set;
  int    lat_clr;
  item_t sb_q[$];

  scanline_sync_top #(
    .LINE_CLKS   (L),
    .HBLANK_CLKS (HB),
    .LINES       (NL),
    .DATA_W      (8),
    .ADDR_W      (4),
    .SYNC_STAGES (SYN),
    .LINE_ADDR   (8'h3),
    .WAIT_ADDR   (8'h2)
  ) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cpu_rdy   (cpu_rdy),
    .hblank    (hblank)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (rst_n) cyc <= cyc + 1;
  end

  function automatic int cur_n();
    return (cyc >= SYN) ? cyc - SYN : 0;
  endfunction

  function automatic int exp_hc(int n);
    return n % L;
  endfunction

  function automatic int exp_line(int n);
    return (n / L) % NL;
  endfunction

  function automatic int exp_rdy(int c);
    return (c > lat_set && c < lat_clr) ? 0 : 1;
  endfunction

  task automatic push(int due, int kind, int expv, string tag);
    item_t it;
    it.due  = due;
    it.kind = kind;
    it.expv = expv;
    it.tag  = tag;
    sb_q.push_back(it);
  endtask

  task automatic push_generic(string rdy_tag);
    push(cyc, K_HBLANK, (exp_hc(cur_n()) < HB) ? 1 : 0, "R2");
    push(cyc, K_RDY, exp_rdy(cyc), rdy_tag);
  endtask

  // monitor: pops the items due this cycle and compares them
  always @(negedge clk) begin
    item_t keep[$];
    int    act;
    #2;
    keep = {};
    foreach (sb_q[i]) begin
      if (sb_q[i].due == cyc) begin
        case (sb_q[i].kind)
          K_RDATA: act = int'(bus_rdata);
          K_RDY:   act = int'(cpu_rdy);
          default: act = int'(hblank);
        endcase
        checks++;
        if (act != sb_q[i].expv) begin
          errors++;
          $display("FAIL %s: kind %0d cycle %0d actual %0d expected %0d",
                   sb_q[i].tag, sb_q[i].kind, cyc, act, sb_q[i].expv);
        end
      end else begin
        keep.push_back(sb_q[i]);
      end
    end
    sb_q = keep;
  end

  task automatic step(string rdy_tag = "R8");
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0; bus_addr = 4'h0; bus_wdata = 8'h00;
    push_generic(rdy_tag);
  endtask

  task automatic rd(logic [3:0] addr, logic sel, string tag);
    int e;
    @(negedge clk);
    bus_sel = sel; bus_we = 1'b0; bus_addr = addr; bus_wdata = 8'h00;
    e = (sel && addr == A_LINE) ? (exp_line(cur_n()) >> 1) : 0;
    push(cyc, K_RDATA, e, tag);
    push_generic(tag);
  endtask

  task automatic wr(logic [3:0] addr, logic [7:0] data, string tag);
    int hc0;
    int j;
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = addr; bus_wdata = data;
    push(cyc, K_RDATA, 0, "R6");
    push_generic(tag);
    if (addr == A_WAIT) begin
      hc0 = exp_hc(cur_n());
      j = (hc0 == L - 1) ? L + 1 : L - hc0;
      lat_set = cyc;
      lat_clr = cyc + j;
      push(cyc + 1, K_RDY, 0, "R7");
      push(lat_clr - 1, K_RDY, 0, tag);
      push(lat_clr, K_RDY, 1, tag);
      push(lat_clr, K_HBLANK, 1, tag);
    end
  endtask

  task automatic goto_pos(int frame, int line, int hc);
    int target;
    target = frame * NL * L + line * L + hc;
    while (cur_n() < target - 1) step();
  endtask

  initial begin
    done = 1'b0;
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: cycle %0d actual running expected finished", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    cyc = 0; checks = 0; errors = 0;
    lat_set = -10; lat_clr = -10;
    rst_n = 1'b0;
    bus_sel = 1'b0; bus_we = 1'b0; bus_addr = 4'h0; bus_wdata = 8'h00;

    // R1: reset state
    rd(A_LINE, 1'b1, "R1");
    rd(A_LINE, 1'b1, "R1");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) step();

    // R2: blanking window over two lines
    repeat (2 * L) step();

    // R5: two-line resolution
    goto_pos(0, 3, 4);  rd(A_LINE, 1'b1, "R5");
    goto_pos(0, 4, 4);  rd(A_LINE, 1'b1, "R5");
    goto_pos(0, 5, 4);  rd(A_LINE, 1'b1, "R5");
    goto_pos(0, 6, 4);  rd(A_LINE, 1'b1, "R5");

    // R3: read across a line boundary (line 7 -> 8 changes the value)
    goto_pos(0, 7, L - 2);
    rd(A_LINE, 1'b1, "R3");
    rd(A_LINE, 1'b1, "R3");
    rd(A_LINE, 1'b1, "R3");

    // R6: quiet read data
    rd(A_WAIT, 1'b1, "R6");
    rd(4'hF, 1'b1, "R6");
    rd(A_LINE, 1'b0, "R6");
    wr(4'hF, 8'hAA, "R6");

    // R7/R8: wait write mid line and at first blank clock
    goto_pos(0, 10, 10);
    wr(A_WAIT, 8'h00, "R8");
    repeat (L) step();
    goto_pos(0, 12, 0);
    wr(A_WAIT, 8'hFF, "R8");
    repeat (L + 2) step();

    // R9: wait write on the final clock of a line
    goto_pos(0, 15, L - 1);
    wr(A_WAIT, 8'h3C, "R9");
    repeat (L + 3) step("R9");

    // R10: non-arming accesses
    goto_pos(0, 18, 5);
    wr(A_LINE, 8'h55, "R10");
    wr(4'h7, 8'hFF, "R10");
    rd(A_WAIT, 1'b1, "R10");
    step("R10");
    step("R10");
    rd(A_LINE, 1'b1, "R10");

    // R4: frame wrap
    goto_pos(0, NL - 1, 3);
    rd(A_LINE, 1'b1, "R4");
    goto_pos(1, 0, 3);
    rd(A_LINE, 1'b1, "R4");
    goto_pos(1, 2, 3);
    rd(A_LINE, 1'b1, "R4");
    repeat (3) step();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule